// File: doc/BRIEF.md
# Pin-Strap Frequency Plan Decoder

This block turns two board-level strap fields into the full set of divider settings for a clock-translation PLL. A 4-bit input-select strap names the reference frequency and a 6-bit output-select strap names the output frequency pair. Each strap pin has a pull-up, so an open pin reads 1 and a grounded pin reads 0. The straps pass through a two-flop synchronizer, are captured once on the first clock after reset is released, and are ignored from then until the next reset.

From the captured pair the block derives the reference-path settings (divide-by-5 enable, doubler enable, R), the feedback settings (N, charge-pump code), the output-path settings (VCO prescaler P0, output dividers P1 and P2) and a loop-bandwidth select that follows the size of N. Some output codes are legal only with one particular input code, and several codes are undefined. An illegal pair raises `config_error` and drives a fixed safe set of divider values. A legal pair raises `config_valid`. Both flags and all settings stay fixed until the next reset.

Top module: `freq_plan_decoder`

## Requirements
- R1: While `rst_n` is low, `config_valid` and `config_error` are 0 and the settings hold their safe values. The straps are captured at the first rising edge with `rst_n` high. Exactly one of the two flags goes high at the second rising edge and not at the first.
- R2: The reference path decodes the input code as {div5, dbl, R}: 0001→{0,1,1}, 0010→{0,0,96}, 0011→{0,0,128}, 0100→{0,0,1024}, 0101→{0,0,1215}, 0110→{0,1,3125}, 0111→{0,0,2430}, 1000→{0,0,3840}, 1001→{0,0,4860}, 1010→{0,0,7680}, 1011→{1,1,3125}, 1100→{0,1,193}, 1101→{0,0,59}, 1110→{0,0,16}, 1111→{0,0,5000}.
- R3: Output codes 1 to 21 give P0=5. P1 and P2 are the pairs (a,b) with a≤b from the list 3,6,12,45,360,480, counted in order (so 000001→3,3; 001101→12,45; 010011→360,360). Codes 22 to 51 and 63 follow the fixed output table (for example 011001→6,5,5; 101110→6,1,2; 111111→5,6,30).
- R4: N and the charge-pump code depend on the input group and the output range. For inputs 0001–1100, output ranges 1–21, 22–27, 28–33, 34–38, 39–43 and 44 give N = 230400, 234375, 233280, 230400, 225000 and 231600, each with CP=121. Input 1111 uses the same ranges with N = 276480, 281250, 279936, 276480, 270000 and 277920, each with CP=145. Input 1101 with outputs 45–50 gives N=1512 and CP=255. Input 1110 with output 51 gives N=768 and with output 63 gives N=2400, both with CP=121.
- R5: `bw_low` is 1 exactly when a valid N is 16384 or more.
- R6: Input code 0000 raises `config_error`.
- R7: Output codes 45–50 are legal only with input 1101, and output 51 only with input 1110. Input 1101 accepts no other output code, and input 1110 accepts only 51 and 63.
- R8: Output codes 0 and 52–62 are errors with every input. Code 63 is also an error with inputs 0001–1100 and 1111, so all-open straps (1111/111111) are an error.
- R9: On error, `config_valid` is 0 and the settings are div5=0, dbl=0, R=1, N=32, CP=0, P0=11, P1=P2=1023, bw_low=0. The two flags are never both 1.
- R10: Strap changes after capture have no effect on any output until reset is asserted again. After that reset, the new straps are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_in | input | 4 | Input-select strap (open = 1) |
| strap_out | input | 6 | Output-select strap (open = 1) |
| ref_div5_en | output | 1 | Reference divide-by-5 enable |
| ref_dbl_en | output | 1 | Reference doubler enable |
| r_div | output | 14 | Reference divider R |
| n_div | output | 20 | Feedback divider N |
| cp_code | output | 8 | Charge-pump current code |
| p0_div | output | 4 | VCO prescaler P0 |
| p1_div | output | 10 | Output 1 divider |
| p2_div | output | 10 | Output 2 divider |
| bw_low | output | 1 | Low loop-bandwidth select |
| config_valid | output | 1 | Captured straps form a legal plan |
| config_error | output | 1 | Captured straps are illegal |

## Verification
The hardest situation to reach from the ports is a strap change after capture, because the straps then reach the synchronizer and the decoder inputs but must not reach the registered outputs. The bench first lets a legal pair settle and checks its results. It then drives a different legal pair and waits well past the synchronizer depth, checking that every setting still shows the first pair. Finally it pulses reset and checks that the second pair appears. Cross-legality is reached by pairing each restricted output code with an input code it does not accept.

// File: rtl/freq_plan_pkg.sv
// Shared widths, settings records and safe values for the strap decoder.
// Assumes a single clock domain after the strap synchronizer.
package freq_plan_pkg;
    localparam int IN_W  = 4;
    localparam int OUT_W = 6;
    localparam int R_W   = 14;
    localparam int N_W   = 20;
    localparam int CP_W  = 8;
    localparam int P0_W  = 4;
    localparam int PO_W  = 10;

    localparam int LOW_BW_N_MIN = 16384;

    localparam logic [R_W-1:0]  SAFE_R  = R_W'(1);
    localparam logic [N_W-1:0]  SAFE_N  = N_W'(32);
    localparam logic [CP_W-1:0] SAFE_CP = '0;
    localparam logic [P0_W-1:0] SAFE_P0 = P0_W'(11);
    localparam logic [PO_W-1:0] SAFE_PO = PO_W'(1023);

    typedef struct packed {
        logic           div5;
        logic           dbl;
        logic [R_W-1:0] r;
    } ref_cfg_t;

    typedef struct packed {
        logic [N_W-1:0]  n;
        logic [CP_W-1:0] cp;
    } fb_cfg_t;

    typedef struct packed {
        logic [P0_W-1:0] p0;
        logic [PO_W-1:0] p1;
        logic [PO_W-1:0] p2;
    } out_cfg_t;
endpackage

// File: rtl/strap_sync.sv
// Multi-stage synchronizer for static strap pins.
// Assumes straps are quasi-static; bits are synchronized independently.
// No reset: the chain is flushed by holding reset for at least STAGES cycles.
module strap_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the asynchronous pins
                always_ff @(posedge clk) chain[0] <= d;
            end else begin : g_next
                // Later stages resolve metastability
                always_ff @(posedge clk) chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ref_path_decode.sv
// Maps the input-select code to divide-by-5, doubler and R settings.
// Code 0 is unused and reported as not ok.
module ref_path_decode
    import freq_plan_pkg::*;
(
    input  logic [IN_W-1:0] in_code,
    output ref_cfg_t        cfg,
    output logic            ok
);
    // Table lookup of the reference path settings
    always_comb begin
        ok  = 1'b1;
        cfg = '{div5: 1'b0, dbl: 1'b0, r: SAFE_R};
        case (in_code)
            4'd1:  cfg = '{1'b0, 1'b1, R_W'(1)};
            4'd2:  cfg = '{1'b0, 1'b0, R_W'(96)};
            4'd3:  cfg = '{1'b0, 1'b0, R_W'(128)};
            4'd4:  cfg = '{1'b0, 1'b0, R_W'(1024)};
            4'd5:  cfg = '{1'b0, 1'b0, R_W'(1215)};
            4'd6:  cfg = '{1'b0, 1'b1, R_W'(3125)};
            4'd7:  cfg = '{1'b0, 1'b0, R_W'(2430)};
            4'd8:  cfg = '{1'b0, 1'b0, R_W'(3840)};
            4'd9:  cfg = '{1'b0, 1'b0, R_W'(4860)};
            4'd10: cfg = '{1'b0, 1'b0, R_W'(7680)};
            4'd11: cfg = '{1'b1, 1'b1, R_W'(3125)};
            4'd12: cfg = '{1'b0, 1'b1, R_W'(193)};
            4'd13: cfg = '{1'b0, 1'b0, R_W'(59)};
            4'd14: cfg = '{1'b0, 1'b0, R_W'(16)};
            4'd15: cfg = '{1'b0, 1'b0, R_W'(5000)};
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/out_path_decode.sv
// Maps the output-select code to P0, P1 and P2.
// Codes 1..21 enumerate ordered divider pairs from a six-entry list;
// the rest come from a fixed table. Codes 0 and 52..62 are not ok.
module out_path_decode
    import freq_plan_pkg::*;
#(
    parameter int PAIR_LIST_LEN = 6
) (
    input  logic [OUT_W-1:0] out_code,
    output out_cfg_t         cfg,
    output logic             ok
);
    localparam int PAIR_CODES = PAIR_LIST_LEN * (PAIR_LIST_LEN + 1) / 2;

    function automatic logic [PO_W-1:0] pair_div(input int idx);
        case (idx)
            0:       pair_div = PO_W'(3);
            1:       pair_div = PO_W'(6);
            2:       pair_div = PO_W'(12);
            3:       pair_div = PO_W'(45);
            4:       pair_div = PO_W'(360);
            default: pair_div = PO_W'(480);
        endcase
    endfunction

    out_cfg_t pair_cfg;

    // Enumerate (a<=b) pairs and pick the one the code counts to
    always_comb begin
        int cnt;
        cnt      = 0;
        pair_cfg = '{p0: P0_W'(5), p1: SAFE_PO, p2: SAFE_PO};
        for (int i = 0; i < PAIR_LIST_LEN; i++) begin
            for (int j = 0; j < PAIR_LIST_LEN; j++) begin
                if (j >= i) begin
                    cnt = cnt + 1;
                    if (cnt == int'(out_code)) begin
                        pair_cfg.p1 = pair_div(i);
                        pair_cfg.p2 = pair_div(j);
                    end
                end
            end
        end
    end

    // Select between the pair enumeration and the fixed table
    always_comb begin
        ok  = 1'b1;
        cfg = '{p0: SAFE_P0, p1: SAFE_PO, p2: SAFE_PO};
        if (out_code != '0 && int'(out_code) <= PAIR_CODES) begin
            cfg = pair_cfg;
        end else begin
            case (out_code)
                6'd22: cfg = '{4'd6, 10'd4,   10'd4};
                6'd23: cfg = '{4'd6, 10'd4,   10'd5};
                6'd24: cfg = '{4'd6, 10'd4,   10'd25};
                6'd25: cfg = '{4'd6, 10'd5,   10'd5};
                6'd26: cfg = '{4'd6, 10'd5,   10'd25};
                6'd27: cfg = '{4'd6, 10'd25,  10'd25};
                6'd28: cfg = '{4'd6, 10'd4,   10'd4};
                6'd29: cfg = '{4'd6, 10'd4,   10'd8};
                6'd30: cfg = '{4'd6, 10'd4,   10'd32};
                6'd31: cfg = '{4'd6, 10'd8,   10'd8};
                6'd32: cfg = '{4'd6, 10'd8,   10'd32};
                6'd33: cfg = '{4'd6, 10'd32,  10'd32};
                6'd34: cfg = '{4'd6, 10'd4,   10'd4};
                6'd35: cfg = '{4'd6, 10'd4,   10'd5};
                6'd36: cfg = '{4'd6, 10'd4,   10'd10};
                6'd37: cfg = '{4'd6, 10'd4,   10'd300};
                6'd38: cfg = '{4'd6, 10'd4,   10'd400};
                6'd39: cfg = '{4'd6, 10'd6,   10'd6};
                6'd40: cfg = '{4'd6, 10'd6,   10'd12};
                6'd41: cfg = '{4'd6, 10'd6,   10'd24};
                6'd42: cfg = '{4'd6, 10'd12,  10'd12};
                6'd43: cfg = '{4'd6, 10'd12,  10'd24};
                6'd44: cfg = '{4'd6, 10'd400, 10'd400};
                6'd45: cfg = '{4'd6, 10'd1,   10'd1};
                6'd46: cfg = '{4'd6, 10'd1,   10'd2};
                6'd47: cfg = '{4'd6, 10'd1,   10'd4};
                6'd48: cfg = '{4'd6, 10'd2,   10'd2};
                6'd49: cfg = '{4'd6, 10'd2,   10'd4};
                6'd50: cfg = '{4'd6, 10'd4,   10'd4};
                6'd51: cfg = '{4'd6, 10'd1,   10'd1};
                6'd63: cfg = '{4'd5, 10'd6,   10'd30};
                default: ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fb_path_decode.sv
// Chooses N and the charge-pump code from the (input group, output range)
// pair. Also owns the cross-legality rule: a pair with no defined N is
// reported as not ok.
module fb_path_decode
    import freq_plan_pkg::*;
(
    input  logic [IN_W-1:0]  in_code,
    input  logic [OUT_W-1:0] out_code,
    output fb_cfg_t          cfg,
    output logic             ok
);
    logic [2:0] range_idx;   // 0..5 defined ranges, 7 = outside
    logic       std_group;   // inputs 1..12
    logic       hi_group;    // input 15

    // Classify the output code into its feedback range
    always_comb begin
        if (out_code >= 6'd1 && out_code <= 6'd21)       range_idx = 3'd0;
        else if (out_code >= 6'd22 && out_code <= 6'd27) range_idx = 3'd1;
        else if (out_code >= 6'd28 && out_code <= 6'd33) range_idx = 3'd2;
        else if (out_code >= 6'd34 && out_code <= 6'd38) range_idx = 3'd3;
        else if (out_code >= 6'd39 && out_code <= 6'd43) range_idx = 3'd4;
        else if (out_code == 6'd44)                      range_idx = 3'd5;
        else                                             range_idx = 3'd7;
    end

    assign std_group = (in_code >= 4'd1) && (in_code <= 4'd12);
    assign hi_group  = (in_code == 4'd15);

    // Look up N and CP for the pair, or flag it as undefined
    always_comb begin
        ok  = 1'b0;
        cfg = '{n: SAFE_N, cp: SAFE_CP};
        if ((std_group || hi_group) && range_idx != 3'd7) begin
            ok = 1'b1;
            cfg.cp = hi_group ? CP_W'(145) : CP_W'(121);
            case (range_idx)
                3'd0:    cfg.n = hi_group ? N_W'(276480) : N_W'(230400);
                3'd1:    cfg.n = hi_group ? N_W'(281250) : N_W'(234375);
                3'd2:    cfg.n = hi_group ? N_W'(279936) : N_W'(233280);
                3'd3:    cfg.n = hi_group ? N_W'(276480) : N_W'(230400);
                3'd4:    cfg.n = hi_group ? N_W'(270000) : N_W'(225000);
                default: cfg.n = hi_group ? N_W'(277920) : N_W'(231600);
            endcase
        end else if (in_code == 4'd13 && out_code >= 6'd45 && out_code <= 6'd50) begin
            ok  = 1'b1;
            cfg = '{n: N_W'(1512), cp: CP_W'(255)};
        end else if (in_code == 4'd14 && out_code == 6'd51) begin
            ok  = 1'b1;
            cfg = '{n: N_W'(768), cp: CP_W'(121)};
        end else if (in_code == 4'd14 && out_code == 6'd63) begin
            ok  = 1'b1;
            cfg = '{n: N_W'(2400), cp: CP_W'(121)};
        end
    end
endmodule

// File: rtl/freq_plan_decoder.sv
// Top level: synchronizes the straps, captures them once after reset,
// decodes the captured pair and registers the full divider plan with
// valid/error flags. Assumes reset is held for at least SYNC_STAGES cycles
// so the synchronizer holds current strap values at release.
module freq_plan_decoder
    import freq_plan_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOW_BW_MIN  = LOW_BW_N_MIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   strap_in,
    input  logic [OUT_W-1:0]  strap_out,
    output logic              ref_div5_en,
    output logic              ref_dbl_en,
    output logic [R_W-1:0]    r_div,
    output logic [N_W-1:0]    n_div,
    output logic [CP_W-1:0]   cp_code,
    output logic [P0_W-1:0]   p0_div,
    output logic [PO_W-1:0]   p1_div,
    output logic [PO_W-1:0]   p2_div,
    output logic              bw_low,
    output logic              config_valid,
    output logic              config_error
);
    localparam int STRAP_W = IN_W + OUT_W;

    logic [STRAP_W-1:0] strap_sync_q;
    logic               captured;
    logic [IN_W-1:0]    in_lat;
    logic [OUT_W-1:0]   out_lat;
    ref_cfg_t           ref_cfg;
    fb_cfg_t            fb_cfg;
    out_cfg_t           out_cfg;
    logic               ref_ok, fb_ok, out_ok, legal;

    strap_sync #(.W(STRAP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   ({strap_in, strap_out}),
        .q   (strap_sync_q)
    );

    // Capture synchronized straps once, on the first cycle out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            captured <= 1'b0;
            in_lat   <= '1;
            out_lat  <= '1;
        end else if (!captured) begin
            captured <= 1'b1;
            in_lat   <= strap_sync_q[STRAP_W-1 -: IN_W];
            out_lat  <= strap_sync_q[OUT_W-1:0];
        end
    end

    ref_path_decode u_ref (.in_code(in_lat), .cfg(ref_cfg), .ok(ref_ok));
    out_path_decode u_out (.out_code(out_lat), .cfg(out_cfg), .ok(out_ok));
    fb_path_decode  u_fb  (.in_code(in_lat), .out_code(out_lat),
                           .cfg(fb_cfg), .ok(fb_ok));

    assign legal = ref_ok && out_ok && fb_ok;

    // Register the plan, or the safe values when the pair is illegal
    always_ff @(posedge clk) begin
        if (!rst_n || (captured && !legal)) begin
            ref_div5_en  <= 1'b0;
            ref_dbl_en   <= 1'b0;
            r_div        <= SAFE_R;
            n_div        <= SAFE_N;
            cp_code      <= SAFE_CP;
            p0_div       <= SAFE_P0;
            p1_div       <= SAFE_PO;
            p2_div       <= SAFE_PO;
            bw_low       <= 1'b0;
            config_valid <= 1'b0;
            config_error <= rst_n;
        end else if (captured) begin
            ref_div5_en  <= ref_cfg.div5;
            ref_dbl_en   <= ref_cfg.dbl;
            r_div        <= ref_cfg.r;
            n_div        <= fb_cfg.n;
            cp_code      <= fb_cfg.cp;
            p0_div       <= out_cfg.p0;
            p1_div       <= out_cfg.p1;
            p2_div       <= out_cfg.p2;
            bw_low       <= (fb_cfg.n >= N_W'(LOW_BW_MIN));
            config_valid <= 1'b1;
            config_error <= 1'b0;
        end
    end
endmodule

// File: rtl/freq_plan_decoder_chk.sv
// Property checker for freq_plan_decoder, attached by bind.
module freq_plan_decoder_chk
    import freq_plan_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ref_div5_en,
    input logic              ref_dbl_en,
    input logic [R_W-1:0]    r_div,
    input logic [N_W-1:0]    n_div,
    input logic [CP_W-1:0]   cp_code,
    input logic [P0_W-1:0]   p0_div,
    input logic [PO_W-1:0]   p1_div,
    input logic [PO_W-1:0]   p2_div,
    input logic              bw_low,
    input logic              config_valid,
    input logic              config_error
);
    // R1
    reset_flags_chk: assert property (@(posedge clk)
        !rst_n |=> (!config_valid && !config_error));

    // R1
    done_in_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (config_valid || config_error));

    // R9
    excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({config_valid, config_error}));

    // R9
    safe_on_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |-> (n_div == SAFE_N && r_div == SAFE_R && cp_code == SAFE_CP
                          && p0_div == SAFE_P0 && p1_div == SAFE_PO
                          && p2_div == SAFE_PO && !bw_low
                          && !ref_div5_en && !ref_dbl_en));

    // R5
    bw_follows_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
        config_valid |-> (bw_low == (n_div >= N_W'(LOW_BW_N_MIN))));

    // R4
    legal_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        config_valid |-> (n_div >= N_W'(32) && p1_div != '0 && p2_div != '0
                          && p0_div >= P0_W'(5) && p0_div <= P0_W'(11)
                          && r_div != '0));

    // R10
    hold_plan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (config_valid || config_error) |=>
            $stable({ref_div5_en, ref_dbl_en, r_div, n_div, cp_code, p0_div,
                     p1_div, p2_div, bw_low, config_valid, config_error}));
endmodule

bind freq_plan_decoder freq_plan_decoder_chk chk (.*);

// File: tb/freq_plan_decoder_test.sv
`timescale 1ns/1ps
module freq_plan_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] strap_in = 4'hF;
    logic [5:0] strap_out = 6'h3F;
    logic        ref_div5_en, ref_dbl_en, bw_low, config_valid, config_error;
    logic [13:0] r_div;
    logic [19:0] n_div;
    logic [7:0]  cp_code;
    logic [3:0]  p0_div;
    logic [9:0]  p1_div, p2_div;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    freq_plan_decoder uut (
        .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .strap_out(strap_out),
        .ref_div5_en(ref_div5_en), .ref_dbl_en(ref_dbl_en), .r_div(r_div),
        .n_div(n_div), .cp_code(cp_code), .p0_div(p0_div), .p1_div(p1_div),
        .p2_div(p2_div), .bw_low(bw_low), .config_valid(config_valid),
        .config_error(config_error)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Whole-plan comparison
    task automatic check_plan(input string req, input bit d5, input bit dbl,
                              input int r, input int n, input int cp,
                              input int p0, input int p1, input int p2,
                              input bit bw, input bit vld, input bit err);
        check(req, "div5",  ref_div5_en, d5);
        check(req, "dbl",   ref_dbl_en, dbl);
        check(req, "R",     r_div, r);
        check(req, "N",     n_div, n);
        check(req, "CP",    cp_code, cp);
        check(req, "P0",    p0_div, p0);
        check(req, "P1",    p1_div, p1);
        check(req, "P2",    p2_div, p2);
        check(req, "bw",    bw_low, bw);
        check(req, "valid", config_valid, vld);
        check(req, "error", config_error, err);
    endtask

    task automatic check_safe(input string req);
        check_plan(req, 0, 0, 1, 32, 0, 11, 1023, 1023, 0, 0, 1);
    endtask

    // Reset with given straps, release, and wait until the plan is out
    task automatic strap_boot(input logic [3:0] si, input logic [5:0] so);
        @(negedge clk);
        rst_n     = 1'b0;
        strap_in  = si;
        strap_out = so;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_and_timing();
        @(negedge clk);
        rst_n = 1'b0; strap_in = 4'b0110; strap_out = 6'b000001;
        repeat (4) @(negedge clk);
        // R1 reset state
        check_plan("R1", 0, 0, 1, 32, 0, 11, 1023, 1023, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "valid after first edge", config_valid, 0);
        check("R1", "error after first edge", config_error, 0);
        @(negedge clk);
        check("R1", "valid after second edge", config_valid, 1);
        // R2 R3 R4 R5 input 0110 / output 000001
        check_plan("R2", 0, 1, 3125, 230400, 121, 5, 3, 3, 1, 1, 0);
    endtask

    task automatic t_legal_plans();
        strap_boot(4'b1111, 6'b011001);
        check_plan("R4", 0, 0, 5000, 281250, 145, 6, 5, 5, 1, 1, 0);
        strap_boot(4'b1101, 6'b101110);
        check_plan("R5", 0, 0, 59, 1512, 255, 6, 1, 2, 0, 1, 0);
        strap_boot(4'b1110, 6'b111111);
        check_plan("R3", 0, 0, 16, 2400, 121, 5, 6, 30, 0, 1, 0);
        strap_boot(4'b1110, 6'b110011);
        check_plan("R7", 0, 0, 16, 768, 121, 6, 1, 1, 0, 1, 0);
        strap_boot(4'b1011, 6'b010101);
        check_plan("R2", 1, 1, 3125, 230400, 121, 5, 480, 480, 1, 1, 0);
        strap_boot(4'b1100, 6'b101100);
        check_plan("R4", 0, 1, 193, 231600, 121, 6, 400, 400, 1, 1, 0);
        strap_boot(4'b0100, 6'b010011);
        check_plan("R3", 0, 0, 1024, 230400, 121, 5, 360, 360, 1, 1, 0);
        strap_boot(4'b0111, 6'b001101);
        check_plan("R3", 0, 0, 2430, 230400, 121, 5, 12, 45, 1, 1, 0);
        strap_boot(4'b1111, 6'b100111);
        check_plan("R4", 0, 0, 5000, 270000, 145, 6, 6, 6, 1, 1, 0);
    endtask

    task automatic t_illegal_plans();
        strap_boot(4'b0000, 6'b000001);
        check_safe("R6");
        strap_boot(4'b0011, 6'b101101);
        check_safe("R7");
        strap_boot(4'b1101, 6'b000001);
        check_safe("R7");
        strap_boot(4'b1110, 6'b000101);
        check_safe("R7");
        strap_boot(4'b0001, 6'b111111);
        check_safe("R8");
        strap_boot(4'b1111, 6'b111010);
        check_safe("R8");
        strap_boot(4'b0101, 6'b000000);
        check_safe("R8");
        strap_boot(4'b1111, 6'b111111);
        check_safe("R9");
    endtask

    task automatic t_strap_ignored();
        strap_boot(4'b0110, 6'b000001);
        check_plan("R10", 0, 1, 3125, 230400, 121, 5, 3, 3, 1, 1, 0);
        strap_in  = 4'b1101;
        strap_out = 6'b110000;
        repeat (10) @(negedge clk);
        check_plan("R10", 0, 1, 3125, 230400, 121, 5, 3, 3, 1, 1, 0);
        strap_in  = 4'b0000;
        repeat (6) @(negedge clk);
        check("R10", "valid held after change to illegal", config_valid, 1);
        check("R10", "error held after change to illegal", config_error, 0);
        strap_boot(4'b1101, 6'b110000);
        check_plan("R10", 0, 0, 59, 1512, 255, 6, 2, 2, 0, 1, 0);
    endtask

    initial begin
        t_reset_and_timing();
        t_legal_plans();
        t_illegal_plans();
        t_strap_ignored();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5.0);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule